// File: doc/BRIEF.md
# Timing Receiver Broadcast Capture

This block sits beside a timing-and-control receiver and turns its strobe-qualified outputs into registers that a host can read. Two broadcast subfields are held in separate latches, each refreshed only by its own strobe. A 4-bit qualifier is latched on the data strobe. On that same strobe the accompanying dump byte is stored in a 16-entry RAM. The RAM entry is chosen by the qualifier value presented in that cycle, not by a write counter.

The host reads through a synchronous port. Word address 0 returns the broadcast register, word 1 the qualifier, word 2 the most recent dump byte, and words 16 to 31 the dump RAM entries 0 to 15. All strobes are single-cycle enables in the system clock domain. A strobe held high for several cycles captures once in every one of those cycles.

Top module: `tcr_capture`

## Requirements
- R1: When `bstb_lo` is high at a rising edge, `bcast_in[5:2]` is stored and appears in bits 5..2 of word 0. While `bstb_lo` is low those bits keep their value.
- R2: When `bstb_hi` is high at a rising edge, `bcast_in[7:6]` is stored and appears in bits 7..6 of word 0. While `bstb_hi` is low those bits keep their value.
- R3: Bits 1..0 and 15..8 of word 0 always read as zero.
- R4: When `qual_stb` is high at a rising edge, `qual_in` is stored and read in bits 3..0 of word 1. Bits 15..4 of word 1 read as zero.
- R5: When `qual_stb` is high at a rising edge, `dump_in` is written to RAM entry `qual_in`. Entry k reads at word address 16+k, with the byte in bits 7..0 and zeros in bits 15..8.
- R6: The RAM has no write path from the read port. Word addresses 3 to 15 read as zero.
- R7: A read issued with `rd_en` high at a rising edge returns its word on `rd_data` after exactly that one edge, with `rd_valid` high for that one cycle. `rd_valid` is low in the cycle after an edge at which `rd_en` was low.
- R8: A read and a capture that hit the same location at the same edge return the value held before that capture.
- R9: A strobe held high over several consecutive edges captures at every one of those edges. The value seen afterwards is the one presented at the last of them.
- R10: Reset (`rst_n` low) clears every capture register, every RAM entry, `rd_data` and `rd_valid` to zero.
- R11: Word 2 holds the dump byte from the most recent `qual_stb` in bits 7..0, with zeros in bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bcast_in | input | 8 | Broadcast data from the receiver |
| bstb_lo | input | 1 | Strobe qualifying broadcast bits 5..2 |
| bstb_hi | input | 1 | Strobe qualifying broadcast bits 7..6 |
| qual_in | input | 4 | Qualifier value, also the dump RAM index |
| qual_stb | input | 1 | Data strobe for the qualifier and the dump byte |
| dump_in | input | 8 | Dump data byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 16 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data valid |

## Verification
The assertions assume that every strobe and data input is already synchronous to `clk`, free of X, and stable around each rising edge. They also assume that any 4-bit qualifier is a legal RAM index. The bench drives all inputs only on falling edges, from fully defined values. It walks the qualifier over every value, so these assumptions always hold. Reads are checked against a behavioural model that takes a read's value before applying that edge's captures. This makes the same-edge ordering of R8 part of every comparison.

// File: rtl/tcr_cap_pkg.sv
package tcr_cap_pkg;
  localparam int BUS_W   = 16;
  localparam int A_BCAST = 0;
  localparam int A_QUAL  = 1;
  localparam int A_LAST  = 2;

  // place the two broadcast subfields into their bus word positions
  function automatic logic [BUS_W-1:0] bcast_pack(input logic [3:0] lo, input logic [1:0] hi);
    logic [BUS_W-1:0] w;
    w = '0;
    w[5:2] = lo;
    w[7:6] = hi;
    return w;
  endfunction

  // true when a word address falls inside the RAM window
  function automatic logic in_window(input int addr, input int base, input int depth);
    return (addr >= base) && (addr < base + depth);
  endfunction
endpackage

// File: rtl/tcr_field_latch.sv
module tcr_field_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/tcr_dump_store.sv
module tcr_dump_store #(
  parameter int QW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [QW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [QW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << QW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == QW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R5: a written byte lands at the entry named by the address given with it
  assert_store_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tcr_read_port.sv
module tcr_read_port
  import tcr_cap_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int QW       = 4,
  parameter int RAM_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BUS_W-1:0]  bcast_word,
  input  logic [BUS_W-1:0]  qual_word,
  input  logic [BUS_W-1:0]  last_word,
  input  logic [BUS_W-1:0]  ram_word,
  output logic [QW-1:0]     ram_idx,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << QW;

  logic [ADDR_W-1:0] win_off;
  logic              hit_ram;
  logic [BUS_W-1:0]  sel_word;

  assign win_off = rd_addr - ADDR_W'(RAM_BASE);
  assign ram_idx = win_off[QW-1:0];
  assign hit_ram = in_window(int'(rd_addr), RAM_BASE, DEPTH);

  always_comb begin
    sel_word = '0;
    if (hit_ram)                        sel_word = ram_word;
    else if (rd_addr == ADDR_W'(A_BCAST)) sel_word = bcast_word;
    else if (rd_addr == ADDR_W'(A_QUAL))  sel_word = qual_word;
    else if (rd_addr == ADDR_W'(A_LAST))  sel_word = last_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_word;
    end
  end

  // R7: one-cycle read latency with a matching valid pulse
  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R6: unmapped words return zero
  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_ram && rd_addr > ADDR_W'(A_LAST)) |=> rd_data == '0);
endmodule

// File: rtl/tcr_capture.sv
module tcr_capture
  import tcr_cap_pkg::*;
#(
  parameter int QW       = 4,
  parameter int DW       = 8,
  parameter int ADDR_W   = 5,
  parameter int RAM_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bcast_in,
  input  logic              bstb_lo,
  input  logic              bstb_hi,
  input  logic [QW-1:0]     qual_in,
  input  logic              qual_stb,
  input  logic [DW-1:0]     dump_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);
  // capture events, named for the assertions
  logic ev_cap_lo, ev_cap_hi, ev_cap_dq;
  assign ev_cap_lo = bstb_lo;
  assign ev_cap_hi = bstb_hi;
  assign ev_cap_dq = qual_stb;

  logic [3:0]    bcast_lo_q;
  logic [1:0]    bcast_hi_q;
  logic [QW-1:0] qual_q;
  logic [DW-1:0] last_q;
  logic [DW-1:0] ram_byte;
  logic [QW-1:0] ram_idx;

  tcr_field_latch #(.W(4)) u_lo (
    .clk(clk), .rst_n(rst_n), .en(ev_cap_lo), .d(bcast_in[5:2]), .q(bcast_lo_q));
  tcr_field_latch #(.W(2)) u_hi (
    .clk(clk), .rst_n(rst_n), .en(ev_cap_hi), .d(bcast_in[7:6]), .q(bcast_hi_q));
  tcr_field_latch #(.W(QW)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(ev_cap_dq), .d(qual_in), .q(qual_q));
  tcr_field_latch #(.W(DW)) u_last (
    .clk(clk), .rst_n(rst_n), .en(ev_cap_dq), .d(dump_in), .q(last_q));

  tcr_dump_store #(.QW(QW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(ev_cap_dq), .waddr(qual_in), .wdata(dump_in),
    .raddr(ram_idx), .rdata(ram_byte));

  logic [BUS_W-1:0] bcast_word, qual_word, last_word, ram_word;
  assign bcast_word = bcast_pack(bcast_lo_q, bcast_hi_q);
  assign qual_word  = BUS_W'(qual_q);
  assign last_word  = BUS_W'(last_q);
  assign ram_word   = BUS_W'(ram_byte);

  tcr_read_port #(.ADDR_W(ADDR_W), .QW(QW), .RAM_BASE(RAM_BASE)) u_port (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .bcast_word(bcast_word), .qual_word(qual_word), .last_word(last_word),
    .ram_word(ram_word), .ram_idx(ram_idx), .rd_data(rd_data), .rd_valid(rd_valid));

  assert_bcast_lo_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap_lo |=> bcast_lo_q == $past(bcast_in[5:2]));
  assert_bcast_lo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cap_lo |=> $stable(bcast_lo_q));
  assert_bcast_hi_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap_hi |=> bcast_hi_q == $past(bcast_in[7:6]));
  assert_bcast_hi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cap_hi |=> $stable(bcast_hi_q));
  assert_bcast_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(A_BCAST)) |=> (rd_data[15:8] == '0 && rd_data[1:0] == '0));
  assert_qual_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap_dq |=> qual_q == $past(qual_in));
  assert_old_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(A_QUAL) && ev_cap_dq) |=> rd_data == BUS_W'($past(qual_q)));
  assert_last_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap_dq |=> last_q == $past(dump_in));
endmodule

// File: tb/tcr_capture_tb_top.sv
`timescale 1ns/1ps
module tcr_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bcast_in = '0;
  logic        bstb_lo = 1'b0, bstb_hi = 1'b0, qual_stb = 1'b0, rd_en = 1'b0;
  logic [3:0]  qual_in = '0;
  logic [7:0]  dump_in = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  always #2.5 clk = ~clk;

  tcr_capture dut_i (
    .clk(clk), .rst_n(rst_n), .bcast_in(bcast_in), .bstb_lo(bstb_lo), .bstb_hi(bstb_hi),
    .qual_in(qual_in), .qual_stb(qual_stb), .dump_in(dump_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string phase  = "R10";

  // behavioural reference state
  int    m_lo, m_hi, m_q, m_last;
  int    m_mem[16];
  bit    m_pend;
  int    m_exp;
  string m_tag;

  function automatic int model_read(int a);
    if (a >= 16) return m_mem[a - 16];
    if (a == 0)  return m_lo * 4 + m_hi * 64;
    if (a == 1)  return m_q;
    if (a == 2)  return m_last;
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a >= 16) return "R5";
    if (a == 0)  return "R1/R2/R3";
    if (a == 1)  return "R4";
    if (a == 2)  return "R11";
    return "R6";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_q = 0; m_last = 0; m_pend = 0; m_exp = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      m_pend = rd_en;
      if (rd_en) begin
        m_exp = model_read(int'(rd_addr));   // value before this edge's captures (R8)
        m_tag = tag_of(int'(rd_addr));
      end
      if (bstb_lo) m_lo = int'(bcast_in) / 4 % 16;
      if (bstb_hi) m_hi = int'(bcast_in) / 64;
      if (qual_stb) begin
        m_q = int'(qual_in);
        m_mem[int'(qual_in)] = int'(dump_in);
        m_last = int'(dump_in);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_valid !== m_pend) begin
        errors++;
        $display("FAIL R7 phase %s: rd_valid actual %b expected %b", phase, rd_valid, m_pend);
      end
      if (m_pend) begin
        checks++;
        if (rd_data !== 16'(m_exp)) begin
          errors++;
          $display("FAIL %s phase %s: rd_data actual %h expected %h", m_tag, phase, rd_data, 16'(m_exp));
        end
      end
    end
  end

  task automatic idle();
    bstb_lo = 0; bstb_hi = 0; qual_stb = 0; rd_en = 0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 32; a++) begin
      rd_en = 1; rd_addr = 5'(a);
      @(negedge clk);
    end
    rd_en = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values at the ports
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 16'h0) begin
      errors++;
      $display("FAIL R10: actual %b/%h expected 0/0000", rd_valid, rd_data);
    end
    rst_n = 1;
    @(negedge clk);
    phase = "R10"; read_all();

    phase = "R1";
    bcast_in = 8'hFF; bstb_lo = 1; @(negedge clk); idle();
    bcast_in = 8'h00; rd_en = 1; rd_addr = 0; @(negedge clk); idle(); @(negedge clk);

    phase = "R2";
    bcast_in = 8'hC3; bstb_hi = 1; @(negedge clk); idle();
    rd_en = 1; rd_addr = 0; @(negedge clk); idle(); @(negedge clk);

    phase = "R5";
    for (int i = 0; i < 16; i++) begin
      qual_in = 4'(15 - i); dump_in = 8'(8'h11 + i * 23); qual_stb = 1;
      @(negedge clk);
    end
    idle(); read_all();

    phase = "R8";
    qual_in = 4'd5; dump_in = 8'hA5; qual_stb = 1; rd_en = 1; rd_addr = 5'd1;
    @(negedge clk);
    qual_in = 4'd9; dump_in = 8'h3C; rd_addr = 5'd25;
    @(negedge clk);
    qual_stb = 0; rd_addr = 5'd1;
    @(negedge clk);
    rd_addr = 5'd25; @(negedge clk);
    rd_addr = 5'd2;  @(negedge clk);
    idle(); @(negedge clk);

    phase = "R9";
    bstb_lo = 1; bstb_hi = 1;
    for (int i = 0; i < 4; i++) begin
      bcast_in = 8'(i * 8'h55 + 8'h1C); rd_en = 1; rd_addr = 0;
      @(negedge clk);
    end
    idle(); rd_en = 1; rd_addr = 0; @(negedge clk); idle(); @(negedge clk);

    phase = "random";
    for (int n = 0; n < 4000; n++) begin
      bcast_in = 8'($urandom); qual_in = 4'($urandom); dump_in = 8'($urandom);
      bstb_lo  = ($urandom % 4) == 0;
      bstb_hi  = ($urandom % 5) == 0;
      qual_stb = ($urandom % 3) == 0;
      rd_en    = ($urandom % 2) == 0;
      rd_addr  = 5'($urandom);
      @(negedge clk);
    end
    idle(); @(negedge clk);

    phase = "R10";
    rst_n = 0; @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
    read_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule